// File: doc/BRIEF.md
# Loop Hold Timer

This block produces a single hold level that freezes the receiver's gain control, bit synchronisation, frequency correction and signal-strength tracking loops while the analogue front end settles after a disturbance. Three event pulses can start a hold: a gain change caused by switching between the two programmed frequencies, a PLL that has been out of lock, and receiver power-up. The loops themselves are outside this block. They watch the hold level and stop adapting while it is high.

A hold has two timed stages that run one after the other. The first stage counts strobes of the ADC-rate tick. Its length is a power of two chosen by a 2-bit code. The second stage counts strobes of the filter-rate tick. Its length comes from a 3-bit code with a non-linear table, and one code of that table means "hold until the code changes". Both tick strobes are single-cycle enables in the one system clock domain. Both codes are read live on every cycle. Their usual setting is 1 for each, which gives 32 ADC ticks followed by 20 filter ticks.

Top module: `loop_hold_timer`

## Requirements
- R1: A high on any of the three event inputs at a rising clock edge makes `hold_o` high after that edge. If a hold is already in progress, the event restarts it from the beginning of the ADC stage.
- R2: The ADC stage ends on the N-th ADC tick after the event, where N = 16, 32, 64 or 128 for `adc_code` = 0, 1, 2 or 3.
- R3: The filter stage ends on the M-th filter tick counted inside that stage, where M = 16, 20, 24, 28, 32, 40 or 48 for `flt_code` = 0 to 6. `hold_o` goes low after the edge that samples that last tick.
- R4: While `flt_code` = 7 in the filter stage, `hold_o` stays high no matter how many filter ticks arrive. When the code changes to 0–6, the full count for the new code is required, counted from the change.
- R5: The stages run in a fixed order: ADC first, then filter. Filter ticks during the ADC stage are not counted, and ADC ticks during the filter stage are not counted.
- R6: `hold_o` only falls at an edge that samples a filter tick with no event present, or at a reset.
- R7: With no hold in progress, ticks and code changes leave `hold_o` low. It rises only on an event.
- R8: A synchronous reset (`rst` high at an edge) makes `hold_o` low after that edge and returns the block to idle.
- R9: A tick sampled in the same cycle as an event is not counted toward the new hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_tick | input | 1 | ADC-rate enable strobe |
| flt_tick | input | 1 | Filter-rate enable strobe |
| ev_band_switch | input | 1 | Event: gain change from a frequency switch |
| ev_lock_lost | input | 1 | Event: PLL was out of lock |
| ev_power_up | input | 1 | Event: receiver power-up |
| adc_code | input | 2 | ADC stage length code |
| flt_code | input | 3 | Filter stage length code, 7 = indefinite |
| hold_o | output | 1 | Loop freeze level |

## Verification
`hold_o` comes straight from the registered stage state, so every result is visible one edge after the input that causes it. This holds for the rise after an event, for the end of the ADC stage on its N-th tick, and for the fall after the M-th filter tick. The bench changes inputs 2 ns after a rising edge and reads `hold_o` in the same place, so each read shows exactly the edges driven so far. It checks the level one tick before each stage boundary and again right after it. This catches counts that are short by one and counts that are long by one. Filter ticks are mixed into the ADC stage, and ADC ticks into the filter stage, so that any tick counted in the wrong stage moves the fall to the wrong edge.

// File: rtl/lhold_pkg.sv
package lhold_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADC  = 2'd1,
      PH_FLT  = 2'd2
   } phase_t;

   // ADC stage length: a power of two, doubling per code step
   function automatic int adc_span(input int base_log2, input int code);
      return 1 << (base_log2 + code);
   endfunction

   // Filter stage length: linear steps for codes 0..3, double steps for 4..6
   function automatic int flt_span(input int base, input int step, input int code);
      if (code < 4)
         return base + step * code;
      return base + 4 * step + 2 * step * (code - 4);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lhold_trig_merge.sv
module lhold_trig_merge #(
   parameter int N_EV = 3
) (
   input  logic [N_EV-1:0] ev,
   output logic            any_ev
);
   logic [N_EV:0] chain;

   assign chain[0] = 1'b0;
   for (genvar g = 0; g < N_EV; g++) begin : g_or
      assign chain[g+1] = chain[g] | ev[g];
   end
   assign any_ev = chain[N_EV];
endmodule

// File: rtl/lhold_span_decode.sv
module lhold_span_decode
   import lhold_pkg::*;
#(
   parameter int ADC_BASE_LOG2 = 4,
   parameter int FLT_BASE      = 16,
   parameter int FLT_STEP      = 4,
   parameter int LEN_W         = 8,
   parameter bit TABLE_DECODE  = 1'b1
) (
   input  logic [1:0]       adc_code,
   input  logic [2:0]       flt_code,
   output logic [LEN_W-1:0] adc_len,
   output logic [LEN_W-1:0] flt_len,
   output logic             perm
);
   localparam logic [2:0] PERM_CODE = 3'd7;

   assign perm = (flt_code == PERM_CODE);

   if (TABLE_DECODE) begin : g_table
      logic [LEN_W-1:0] adc_tab [4];
      logic [LEN_W-1:0] flt_tab [8];
      for (genvar a = 0; a < 4; a++) begin : g_adc
         assign adc_tab[a] = LEN_W'(adc_span(ADC_BASE_LOG2, a));
      end
      for (genvar f = 0; f < 7; f++) begin : g_flt
         assign flt_tab[f] = LEN_W'(flt_span(FLT_BASE, FLT_STEP, f));
      end
      assign flt_tab[7] = '0;
      assign adc_len = adc_tab[adc_code];
      assign flt_len = flt_tab[flt_code];
   end else begin : g_arith
      always_comb begin
         adc_len = LEN_W'(adc_span(ADC_BASE_LOG2, int'(adc_code)));
         if (perm)
            flt_len = '0;
         else
            flt_len = LEN_W'(flt_span(FLT_BASE, FLT_STEP, int'(flt_code)));
      end
   end
endmodule

// File: rtl/lhold_tick_counter.sv
module lhold_tick_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] len,
   output logic         done
);
   logic [W-1:0] cnt_q;
   logic [W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
   // Compare with >= so a code lowered mid-stage ends on the next tick
   assign done    = tick & ~clr & (cnt_inc >= {1'b0, len});

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= done ? '0 : cnt_inc[W-1:0];
   end
endmodule

// File: rtl/lhold_phase_fsm.sv
module lhold_phase_fsm
   import lhold_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   start,
   input  logic   adc_done,
   input  logic   flt_done,
   output phase_t phase
);
   phase_t phase_d;

   always_comb begin
      phase_d = phase;
      if (start)
         phase_d = PH_ADC;
      else begin
         unique case (phase)
            PH_ADC:  if (adc_done) phase_d = PH_FLT;
            PH_FLT:  if (flt_done) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         phase <= PH_IDLE;
      else
         phase <= phase_d;
   end
endmodule

// File: rtl/loop_hold_timer.sv
module loop_hold_timer
   import lhold_pkg::*;
#(
   parameter int ADC_BASE_LOG2 = 4,
   parameter int FLT_BASE      = 16,
   parameter int FLT_STEP      = 4,
   parameter bit SPLIT_CNT     = 1'b0,
   parameter bit TABLE_DECODE  = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       adc_tick,
   input  logic       flt_tick,
   input  logic       ev_band_switch,
   input  logic       ev_lock_lost,
   input  logic       ev_power_up,
   input  logic [1:0] adc_code,
   input  logic [2:0] flt_code,
   output logic       hold_o
);
   localparam int N_EV    = 3;
   localparam int MAX_LEN = max2(adc_span(ADC_BASE_LOG2, 3),
                                 flt_span(FLT_BASE, FLT_STEP, 6));
   localparam int LEN_W   = $clog2(MAX_LEN + 1);

   if (ADC_BASE_LOG2 < 0 || ADC_BASE_LOG2 > 20) begin : g_bad_adc
      $error("ADC_BASE_LOG2 out of range");
   end
   if (FLT_BASE < 1 || FLT_STEP < 0) begin : g_bad_flt
      $error("filter span parameters out of range");
   end

   logic             any_ev;
   logic [LEN_W-1:0] adc_len;
   logic [LEN_W-1:0] flt_len;
   logic             perm;
   logic             adc_done;
   logic             flt_done;
   phase_t           phase;
   logic             in_adc;
   logic             in_flt;

   lhold_trig_merge #(.N_EV(N_EV)) u_merge (
      .ev     ({ev_power_up, ev_lock_lost, ev_band_switch}),
      .any_ev (any_ev)
   );

   lhold_span_decode #(
      .ADC_BASE_LOG2 (ADC_BASE_LOG2),
      .FLT_BASE      (FLT_BASE),
      .FLT_STEP      (FLT_STEP),
      .LEN_W         (LEN_W),
      .TABLE_DECODE  (TABLE_DECODE)
   ) u_decode (
      .adc_code (adc_code),
      .flt_code (flt_code),
      .adc_len  (adc_len),
      .flt_len  (flt_len),
      .perm     (perm)
   );

   assign in_adc = (phase == PH_ADC);
   assign in_flt = (phase == PH_FLT);

   if (SPLIT_CNT) begin : g_split
      lhold_tick_counter #(.W(LEN_W)) u_adc_cnt (
         .clk  (clk),
         .rst  (rst),
         .clr  (any_ev | ~in_adc),
         .tick (adc_tick & in_adc),
         .len  (adc_len),
         .done (adc_done)
      );
      lhold_tick_counter #(.W(LEN_W)) u_flt_cnt (
         .clk  (clk),
         .rst  (rst),
         .clr  (any_ev | ~in_flt | perm),
         .tick (flt_tick & in_flt),
         .len  (flt_len),
         .done (flt_done)
      );
   end else begin : g_shared
      logic             sh_tick;
      logic             sh_clr;
      logic [LEN_W-1:0] sh_len;
      logic             sh_done;

      assign sh_tick = in_adc ? adc_tick : (in_flt & flt_tick);
      assign sh_len  = in_adc ? adc_len : flt_len;
      assign sh_clr  = any_ev | (~in_adc & ~in_flt) | (in_flt & perm);

      lhold_tick_counter #(.W(LEN_W)) u_cnt (
         .clk  (clk),
         .rst  (rst),
         .clr  (sh_clr),
         .tick (sh_tick),
         .len  (sh_len),
         .done (sh_done)
      );
      assign adc_done = sh_done & in_adc;
      assign flt_done = sh_done & in_flt;
   end

   lhold_phase_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .start    (any_ev),
      .adc_done (adc_done),
      .flt_done (flt_done),
      .phase    (phase)
   );

   assign hold_o = (phase != PH_IDLE);
endmodule

// File: rtl/loop_hold_timer_chk.sv
module loop_hold_timer_chk (
   input logic       clk,
   input logic       rst,
   input logic       adc_tick,
   input logic       flt_tick,
   input logic       ev_band_switch,
   input logic       ev_lock_lost,
   input logic       ev_power_up,
   input logic [1:0] adc_code,
   input logic [2:0] flt_code,
   input logic       hold_o
);
   logic any_ev;
   assign any_ev = ev_band_switch | ev_lock_lost | ev_power_up;

   p_event_raises_r1: assert property (@(posedge clk) disable iff (rst)
      any_ev |=> hold_o);

   p_perm_keeps_r4: assert property (@(posedge clk) disable iff (rst)
      (hold_o && flt_code == 3'd7) |=> hold_o);

   p_fall_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
      ($fell(hold_o) && !$past(rst)) |-> ($past(flt_tick) && !$past(any_ev)));

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      (!hold_o && !any_ev) |=> !hold_o);

   p_reset_clears_r8: assert property (@(posedge clk)
      rst |=> !hold_o);
endmodule

bind loop_hold_timer loop_hold_timer_chk u_chk (
   .clk            (clk),
   .rst            (rst),
   .adc_tick       (adc_tick),
   .flt_tick       (flt_tick),
   .ev_band_switch (ev_band_switch),
   .ev_lock_lost   (ev_lock_lost),
   .ev_power_up    (ev_power_up),
   .adc_code       (adc_code),
   .flt_code       (flt_code),
   .hold_o         (hold_o)
);

// File: tb/loop_hold_timer_test.sv
module loop_hold_timer_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       adc_tick = 1'b0;
   logic       flt_tick = 1'b0;
   logic [2:0] ev = 3'b000;
   logic [1:0] adc_code = 2'd1;
   logic [2:0] flt_code = 3'd1;
   logic       hold_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   loop_hold_timer uut (
      .clk            (clk),
      .rst            (rst),
      .adc_tick       (adc_tick),
      .flt_tick       (flt_tick),
      .ev_band_switch (ev[0]),
      .ev_lock_lost   (ev[1]),
      .ev_power_up    (ev[2]),
      .adc_code       (adc_code),
      .flt_code       (flt_code),
      .hold_o         (hold_o)
   );

   // vector: {event index[1:0], adc code[1:0], filter code[2:0]}
   localparam int NV = 8;
   localparam logic [6:0] VEC [NV] = '{
      {2'd0, 2'd1, 3'd1}, {2'd1, 2'd0, 3'd0}, {2'd2, 2'd2, 3'd2},
      {2'd0, 2'd3, 3'd3}, {2'd1, 2'd0, 3'd4}, {2'd2, 2'd1, 3'd5},
      {2'd0, 2'd0, 3'd6}, {2'd1, 2'd2, 3'd0}
   };

   function automatic int exp_adc(input int c);
      return 16 * (2 ** c);
   endfunction

   function automatic int exp_flt(input int c);
      case (c)
         0: return 16;
         1: return 20;
         2: return 24;
         3: return 28;
         4: return 32;
         5: return 40;
         default: return 48;
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: hold_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // inputs are driven for one rising edge, then released 2 ns after it
   task automatic step(input logic a, input logic f, input logic [2:0] e);
      adc_tick = a;
      flt_tick = f;
      ev = e;
      @(posedge clk);
      #2;
      adc_tick = 1'b0;
      flt_tick = 1'b0;
      ev = 3'b000;
   endtask

   task automatic ticks_adc(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'b000);
   endtask

   task automatic ticks_flt(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b1, 3'b000);
   endtask

   task automatic run_vec(input int ei, input int ac, input int fc);
      int na;
      int nf;
      na = exp_adc(ac);
      nf = exp_flt(fc);
      adc_code = 2'(ac);
      flt_code = 3'(fc);
      step(1'b0, 1'b0, 3'(1 << ei));
      check("R1 event raises hold", hold_o, 1'b1);
      for (int i = 0; i < na; i++) begin
         if (i < 4) step(1'b0, 1'b1, 3'b000);   // R5 filter ticks ignored
         step(1'b1, 1'b0, 3'b000);
      end
      check("R2 hold after ADC stage", hold_o, 1'b1);
      for (int i = 0; i < nf - 1; i++) begin
         if (i < 4) step(1'b1, 1'b0, 3'b000);   // R5 ADC ticks ignored
         step(1'b0, 1'b1, 3'b000);
      end
      check("R3 R5 hold before last filter tick", hold_o, 1'b1);
      step(1'b0, 1'b1, 3'b000);
      check("R3 R6 hold drops after last filter tick", hold_o, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: hold_o=%b expected run to finish", hold_o);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R8 reset state", hold_o, 1'b0);
      rst = 1'b0;

      // R7: ticks and code changes in idle do nothing
      ticks_adc(40);
      flt_code = 3'd7;
      ticks_flt(30);
      check("R7 idle ignores ticks", hold_o, 1'b0);
      flt_code = 3'd1;

      for (int v = 0; v < NV; v++)
         run_vec(int'(VEC[v][6:5]), int'(VEC[v][4:3]), int'(VEC[v][2:0]));

      // R9: tick coincident with the event is not counted
      adc_code = 2'd0;
      flt_code = 3'd0;
      step(1'b1, 1'b1, 3'b001);
      ticks_adc(15);
      ticks_flt(16);
      check("R9 coincident tick not counted", hold_o, 1'b1);
      ticks_adc(1);
      ticks_flt(15);
      check("R9 hold before final filter tick", hold_o, 1'b1);
      ticks_flt(1);
      check("R9 hold released", hold_o, 1'b0);

      // R4: code 7 holds indefinitely, full wait after leaving it
      flt_code = 3'd7;
      step(1'b0, 1'b0, 3'b100);
      ticks_adc(16);
      ticks_flt(60);
      check("R4 code 7 keeps hold", hold_o, 1'b1);
      flt_code = 3'd0;
      ticks_flt(15);
      check("R4 full wait after release", hold_o, 1'b1);
      ticks_flt(1);
      check("R4 hold drops after new wait", hold_o, 1'b0);

      // R1: restart from the ADC stage during the filter stage
      step(1'b0, 1'b0, 3'b010);
      ticks_adc(16);
      ticks_flt(10);
      step(1'b0, 1'b0, 3'b100);
      ticks_flt(16);
      check("R1 restart returns to ADC stage", hold_o, 1'b1);
      ticks_adc(16);
      ticks_flt(15);
      check("R1 restarted hold before end", hold_o, 1'b1);
      ticks_flt(1);
      check("R1 restarted hold ends", hold_o, 1'b0);

      // R8: reset in the middle of a hold
      step(1'b0, 1'b0, 3'b001);
      ticks_adc(5);
      check("R1 hold before reset", hold_o, 1'b1);
      rst = 1'b1;
      step(1'b0, 1'b0, 3'b000);
      rst = 1'b0;
      check("R8 reset clears hold", hold_o, 1'b0);
      ticks_adc(20);
      ticks_flt(20);
      check("R8 R7 idle after reset", hold_o, 1'b0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule